// File: doc/BRIEF.md
# Wishbone SPI Master Controller

This block is an 8-bit Wishbone slave that runs a full-duplex SPI bus as its master. Software programs the serial clock polarity, phase and rate through a control register and a divider register. It then writes one byte to the data address. The block shifts that byte out most-significant bit first while collecting the byte the slave returns. Once the transfer ends, the received byte can be read back from the same data address.

Chip select and a mode line are plain control bits that software sets and clears itself. They are not tied to the transfer. A busy bit in the control register shows whether a transfer is in flight. A transfer-enable bit, which is active low, can inhibit new transfers. The interrupt output exists for bus compatibility and is held low.

Top module: `spi_wb_master`

## Requirements
- R1: After reset, the control register and the divider read 00h and the receive data reads 00h. spi_sclk_o is low, and spi_cs_o and spi_mode_o are low.
- R2: An access where wb_stb_i and wb_cyc_i are sampled high while wb_ack_o is low gets wb_ack_o high in the next cycle for exactly one cycle. Read data is valid on wb_dat_o while wb_ack_o is high. A write takes effect at the edge that samples it.
- R3: The register map has three addresses. Address 2'b00 takes transmit data on write and returns receive data on read. Address 2'b01 is the control register: bit 7 busy (read-only), bits 6:5 read 0 and ignore writes, bit 4 cpha, bit 3 cpol, bit 2 mode, bit 1 cs, bit 0 txen. Address 2'b10 is the clock divider. Address 2'b11 reads 00h, and writes to it change nothing.
- R4: spi_cs_o follows control bit 1 and spi_mode_o follows control bit 2, from the cycle after the write.
- R5: A write to address 2'b00 while txen is 0 and no transfer is running starts a transfer. Busy reads 1 from the next cycle.
- R6: A write to address 2'b00 while txen is 1 has no effect. spi_sclk_o stays at its idle level and busy stays 0.
- R7: While idle, spi_sclk_o equals cpol. A transfer consists of 16 serial clock edges. Each half period lasts divider+1 system clocks, and the first edge comes divider+1 clocks after the starting write is sampled.
- R8: With cpha 0, spi_miso_i is sampled on edges 1, 3, ..., 15, and spi_mosi_o advances on edges 2, 4, ..., 14. With cpha 1, spi_miso_i is sampled on edges 2, 4, ..., 16, and spi_mosi_o advances on edges 3, 5, ..., 15. The MSB is on spi_mosi_o from the start.
- R9: Bits go out MSB first. Received bits enter at bit 0, and after the transfer the whole received byte reads back at address 2'b00.
- R10: Busy clears at the 16th edge, and spi_sclk_o is back at cpol at that point. A data write while busy is ignored and does not disturb the running transfer.
- R11: irq_o is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_stb_i | input | 1 | Wishbone strobe |
| wb_cyc_i | input | 1 | Wishbone cycle |
| wb_we_i | input | 1 | Write enable, 1 = write |
| wb_adr_i | input | 2 | Register address |
| wb_dat_i | input | 8 | Write data |
| wb_ack_o | output | 1 | Access acknowledge |
| wb_dat_o | output | 8 | Read data |
| irq_o | output | 1 | Interrupt, held low |
| spi_sclk_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to the slave |
| spi_miso_i | input | 1 | Serial data from the slave |
| spi_cs_o | output | 1 | Chip select from control bit 1 |
| spi_mode_o | output | 1 | Mode line from control bit 2 |

## Verification
The hardest case to reach is a bus access that lands in the middle of a transfer: reading busy as 1, or writing new data that must be ignored. Both have to hit a window of only a few dozen cycles. The stimulus issues these accesses straight after the starting write, with the divider set high enough that they are sure to fall inside the transfer. It then checks at the pins that the serial output sequence and the received byte are undisturbed. All four clock polarity and phase combinations run with different dividers, and each is compared against a behavioural slave and reference model on every clock.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_DATA = 2'b00,
    ADR_CTRL = 2'b01,
    ADR_DIV  = 2'b10,
    ADR_NONE = 2'b11
  } reg_addr_e;

  typedef struct packed {
    logic cpha;
    logic cpol;
    logic mode;
    logic cs;
    logic txen_n;
  } ctrl_t;

  typedef enum logic {ENG_IDLE, ENG_RUN} eng_state_e;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // half period never shorter than one clock, counter cleared between transfers
  assert_cnt_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng
  import spi_ctl_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [BITS-1:0] tx_i,
  input  logic            cpha_i,
  input  logic            cpol_i,
  input  logic            tick_i,
  input  logic            miso_i,
  output logic            busy_o,
  output logic            sclk_o,
  output logic            mosi_o,
  output logic [BITS-1:0] rx_o
);
  localparam int EDGES = 2 * BITS;
  localparam int EW    = $clog2(EDGES);

  eng_state_e      state_q;
  logic [EW-1:0]   edge_q;
  logic            ph_q;
  logic [BITS-1:0] tx_sh_q, rx_sh_q, rx_q;
  logic            last_edge, do_sample, do_shift;
  logic [BITS-1:0] rx_next;

  assign last_edge = edge_q == EW'(EDGES - 1);
  assign do_sample = cpha_i ? edge_q[0] : ~edge_q[0];
  assign do_shift  = cpha_i ? (~edge_q[0] && edge_q != '0) : (edge_q[0] && !last_edge);
  assign rx_next   = do_sample ? {rx_sh_q[BITS-2:0], miso_i} : rx_sh_q;

  assign busy_o = state_q == ENG_RUN;
  assign sclk_o = cpol_i ^ ph_q;
  assign mosi_o = tx_sh_q[BITS-1];
  assign rx_o   = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      edge_q  <= '0;
      ph_q    <= 1'b0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      rx_q    <= '0;
    end else begin
      unique case (state_q)
        ENG_IDLE: if (start_i) begin
          tx_sh_q <= tx_i;
          edge_q  <= '0;
          ph_q    <= 1'b0;
          state_q <= ENG_RUN;
        end
        ENG_RUN: if (tick_i) begin
          ph_q    <= ~ph_q;
          edge_q  <= edge_q + 1'b1;
          rx_sh_q <= rx_next;
          if (do_shift) tx_sh_q <= {tx_sh_q[BITS-2:0], 1'b0};
          if (last_edge) begin
            rx_q    <= rx_next;
            state_q <= ENG_IDLE;
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assert_sclk_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sclk_o == cpol_i);
  assert_busy_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  assert_end_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> sclk_o == cpol_i);
endmodule

// File: rtl/spi_wb_regs.sv
module spi_wb_regs
  import spi_ctl_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              cyc_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic [REG_W-1:0]  dat_i,
  output logic              ack_o,
  output logic [REG_W-1:0]  dat_o,
  input  logic              busy_i,
  input  logic [REG_W-1:0]  rx_i,
  output ctrl_t             ctrl_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              start_o,
  output logic [REG_W-1:0]  tx_o
);
  logic             ack_q, acc, wr;
  ctrl_t            ctrl_q;
  logic [DIV_W-1:0] div_q;
  logic [REG_W-1:0] dat_q, rd_mux;

  assign acc     = stb_i && cyc_i && !ack_q;
  assign wr      = acc && we_i;
  assign start_o = wr && (adr_i == ADR_DATA) && !ctrl_q.txen_n && !busy_i;
  assign tx_o    = dat_i;

  always_comb begin
    unique case (adr_i)
      ADR_DATA: rd_mux = rx_i;
      ADR_CTRL: rd_mux = {busy_i, 2'b00, ctrl_q};
      ADR_DIV:  rd_mux = REG_W'(div_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      ctrl_q <= '0;
      div_q  <= '0;
      dat_q  <= '0;
    end else begin
      ack_q <= acc;
      if (acc && !we_i) dat_q <= rd_mux;
      if (wr && adr_i == ADR_CTRL) ctrl_q <= dat_i[4:0];
      if (wr && adr_i == ADR_DIV)  div_q  <= DIV_W'(dat_i);
    end
  end

  assign ack_o  = ack_q;
  assign dat_o  = dat_q;
  assign ctrl_o = ctrl_q;
  assign div_o  = div_q;

  assert_ack_next_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && cyc_i && !ack_o) |=> ack_o);
  assert_ack_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
endmodule

// File: rtl/spi_wb_master.sv
module spi_wb_master
  import spi_ctl_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wb_stb_i,
  input  logic       wb_cyc_i,
  input  logic       wb_we_i,
  input  logic [1:0] wb_adr_i,
  input  logic [7:0] wb_dat_i,
  output logic       wb_ack_o,
  output logic [7:0] wb_dat_o,
  output logic       irq_o,
  output logic       spi_sclk_o,
  output logic       spi_mosi_o,
  input  logic       spi_miso_i,
  output logic       spi_cs_o,
  output logic       spi_mode_o
);
  ctrl_t            ctrl;
  logic [DIV_W-1:0] div;
  logic             start, busy, tick;
  logic [REG_W-1:0] tx_byte, rx_byte;

  spi_wb_regs #(.DIV_W(DIV_W)) u_regs (
    .clk_i, .rst_ni,
    .stb_i(wb_stb_i), .cyc_i(wb_cyc_i), .we_i(wb_we_i),
    .adr_i(wb_adr_i), .dat_i(wb_dat_i),
    .ack_o(wb_ack_o), .dat_o(wb_dat_o),
    .busy_i(busy), .rx_i(rx_byte),
    .ctrl_o(ctrl), .div_o(div), .start_o(start), .tx_o(tx_byte)
  );

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .run_i(busy), .div_i(div), .tick_o(tick)
  );

  spi_shift_eng #(.BITS(REG_W)) u_eng (
    .clk_i, .rst_ni,
    .start_i(start), .tx_i(tx_byte),
    .cpha_i(ctrl.cpha), .cpol_i(ctrl.cpol),
    .tick_i(tick), .miso_i(spi_miso_i),
    .busy_o(busy), .sclk_o(spi_sclk_o), .mosi_o(spi_mosi_o), .rx_o(rx_byte)
  );

  assign spi_cs_o   = ctrl.cs;
  assign spi_mode_o = ctrl.mode;
  assign irq_o      = 1'b0;

  assert_pins_follow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_stb_i && wb_cyc_i && !wb_ack_o && wb_we_i && wb_adr_i == 2'b01)
      |=> (spi_cs_o == $past(wb_dat_i[1])) && (spi_mode_o == $past(wb_dat_i[2])));
  assert_inhibit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_stb_i && wb_cyc_i && !wb_ack_o && wb_we_i && wb_adr_i == 2'b00 && ctrl.txen_n && !busy)
      |=> !busy);
endmodule

// File: tb/tb_spi_wb_master.sv
module tb_spi_wb_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b0, cyc = 1'b0, we = 1'b0;
  logic [1:0] adr = 2'b00;
  logic [7:0] dat = 8'h00;
  logic       ack, irq, sclk, mosi, cs, mode;
  logic       miso = 1'b0;
  logic [7:0] dat_o;

  int n_chk = 0, n_fail = 0, cyc_cnt = 0;

  always #2 clk = ~clk;

  spi_wb_master dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wb_stb_i(stb), .wb_cyc_i(cyc), .wb_we_i(we), .wb_adr_i(adr), .wb_dat_i(dat),
    .wb_ack_o(ack), .wb_dat_o(dat_o), .irq_o(irq),
    .spi_sclk_o(sclk), .spi_mosi_o(mosi), .spi_miso_i(miso),
    .spi_cs_o(cs), .spi_mode_o(mode)
  );

  // reference model
  logic       m_ack, m_busy, m_ph;
  logic [7:0] m_dat, m_div, m_tx, m_rx, m_rxsh, m_cap;
  logic [4:0] m_ctrl;
  int         m_cnt, m_edge, m_nsamp;
  logic [7:0] s_byte = 8'h00;

  always @(posedge clk or negedge rst_n) begin : model
    logic       acc, smp, shf;
    logic [7:0] nrx;
    if (!rst_n) begin
      m_ack <= 0; m_busy <= 0; m_ph <= 0; m_dat <= 0; m_div <= 0; m_tx <= 0;
      m_rx <= 0; m_rxsh <= 0; m_cap <= 0; m_ctrl <= 0; m_cnt <= 0; m_edge <= 0; m_nsamp <= 0;
    end else begin
      acc = stb && cyc && !m_ack;
      m_ack <= acc;
      if (acc && !we)
        case (adr)
          2'd0: m_dat <= m_rx;
          2'd1: m_dat <= {m_busy, 2'b00, m_ctrl};
          2'd2: m_dat <= m_div;
          default: m_dat <= 8'h00;
        endcase
      if (acc && we && adr == 2'd1) m_ctrl <= dat[4:0];
      if (acc && we && adr == 2'd2) m_div <= dat;
      if (!m_busy) begin
        if (acc && we && adr == 2'd0 && !m_ctrl[0]) begin
          m_busy <= 1; m_cnt <= 0; m_edge <= 0; m_ph <= 0; m_tx <= dat; m_nsamp <= 0; m_cap <= 0;
        end
      end else if (m_cnt == int'(m_div)) begin
        m_cnt <= 0;
        m_ph <= !m_ph;
        m_edge <= m_edge + 1;
        smp = m_ctrl[4] ? (m_edge % 2 == 1) : (m_edge % 2 == 0);
        shf = m_ctrl[4] ? (m_edge % 2 == 0 && m_edge != 0) : (m_edge % 2 == 1 && m_edge != 15);
        nrx = smp ? {m_rxsh[6:0], miso} : m_rxsh;
        m_rxsh <= nrx;
        if (smp) begin m_nsamp <= m_nsamp + 1; m_cap <= {m_cap[6:0], mosi}; end
        if (shf) m_tx <= {m_tx[6:0], 1'b0};
        if (m_edge == 15) begin m_busy <= 0; m_rx <= nrx; end
      end else m_cnt <= m_cnt + 1;
    end
  end

  // behavioural slave: present next bit after each sample
  always @(negedge clk) miso <= (m_nsamp < 8) ? s_byte[7 - m_nsamp] : 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) if (rst_n) begin
    chk(ack == m_ack, "R2 ack", ack, m_ack);
    if (ack) chk(dat_o == m_dat, "R3 read data", dat_o, m_dat);
    chk(sclk == (m_ctrl[3] ^ m_ph), "R7 sclk", sclk, m_ctrl[3] ^ m_ph);
    chk(mosi == m_tx[7], "R8 mosi", mosi, m_tx[7]);
    chk(cs == m_ctrl[1] && mode == m_ctrl[2], "R4 cs/mode", {cs, mode}, {m_ctrl[1], m_ctrl[2]});
    chk(irq == 1'b0, "R11 irq", irq, 0);
  end

  task automatic wb(input bit w, input logic [1:0] a, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    stb = 1; cyc = 1; we = w; adr = a; dat = d;
    @(negedge clk);
    q = dat_o;
    stb = 0; cyc = 0; we = 0;
  endtask

  task automatic wait_idle();
    logic [7:0] q;
    for (int i = 0; i < 2000; i++) begin
      wb(0, 2'd1, 8'h00, q);
      if (!q[7]) return;
    end
  endtask

  task automatic xfer(input logic [7:0] ctl, input logic [7:0] dv, input logic [7:0] tx,
                      input logic [7:0] slv);
    logic [7:0] q;
    wb(1, 2'd2, dv, q);
    wb(1, 2'd1, ctl, q);
    s_byte = slv;
    wb(1, 2'd0, tx, q);
    wb(0, 2'd1, 8'h00, q);
    chk(q[7] == 1'b1, "R5 busy after start", q, {1'b1, 2'b00, ctl[4:0]});
    wait_idle();
    chk(sclk == ctl[3], "R10 sclk idle after end", sclk, ctl[3]);
    wb(0, 2'd0, 8'h00, q);
    chk(q == slv, "R9 rx byte", q, slv);
    chk(m_cap == tx, "R9 mosi MSB first", m_cap, tx);
  endtask

  initial begin : watchdog
    while (cyc_cnt < 100000) begin @(posedge clk); cyc_cnt++; end
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc_cnt, 100000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    logic [7:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(sclk == 0 && cs == 0 && mode == 0, "R1 pins after reset", {sclk, cs, mode}, 0);
    wb(0, 2'd1, 8'h00, q); chk(q == 8'h00, "R1 ctrl reset", q, 0);
    wb(0, 2'd2, 8'h00, q); chk(q == 8'h00, "R1 div reset", q, 0);
    wb(0, 2'd0, 8'h00, q); chk(q == 8'h00, "R1 rx reset", q, 0);
    // R3 unused bits, R4 pins
    wb(1, 2'd1, 8'hE6, q);
    chk(cs == 1 && mode == 1, "R4 cs/mode set", {cs, mode}, 2'b11);
    wb(0, 2'd1, 8'h00, q); chk(q == 8'h06, "R3 ctrl masked", q, 8'h06);
    wb(1, 2'd2, 8'h9C, q);
    wb(0, 2'd2, 8'h00, q); chk(q == 8'h9C, "R3 div readback", q, 8'h9C);
    wb(1, 2'd3, 8'hFF, q);
    wb(0, 2'd3, 8'h00, q); chk(q == 8'h00, "R3 addr 3 reads zero", q, 0);
    wb(0, 2'd2, 8'h00, q); chk(q == 8'h9C, "R3 addr 3 write ignored", q, 8'h9C);
    // R7 R8 transfers in all four clock modes
    xfer(8'h00, 8'h00, 8'hA5, 8'h3C);
    xfer(8'h08, 8'h02, 8'h5A, 8'hC3);
    xfer(8'h12, 8'h01, 8'h81, 8'h7E);
    xfer(8'h1C, 8'h03, 8'hF0, 8'h0F);
    // R6 inhibit
    wb(1, 2'd1, 8'h09, q);
    wb(1, 2'd0, 8'h55, q);
    repeat (6) @(negedge clk);
    chk(sclk == 1'b1, "R6 sclk stays idle", sclk, 1);
    wb(0, 2'd1, 8'h00, q); chk(q == 8'h09, "R6 busy stays low", q, 8'h09);
    wb(0, 2'd0, 8'h00, q); chk(q == 8'h0F, "R6 rx untouched", q, 8'h0F);
    // R10 data write during a transfer is ignored
    wb(1, 2'd2, 8'h05, q);
    wb(1, 2'd1, 8'h00, q);
    s_byte = 8'h96;
    wb(1, 2'd0, 8'hC6, q);
    wb(1, 2'd0, 8'h00, q);
    wb(0, 2'd1, 8'h00, q); chk(q == 8'h80, "R10 busy during transfer", q, 8'h80);
    wait_idle();
    wb(0, 2'd0, 8'h00, q); chk(q == 8'h96, "R10 rx after ignored write", q, 8'h96);
    chk(m_cap == 8'hC6, "R10 mosi undisturbed", m_cap, 8'hC6);
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule